// File: doc/BRIEF.md
# Stack Machine Execution Core

This core executes a stream of stack-machine instructions against an internal operand stack, one instruction per accepted handshake cycle. Each instruction carries a 4-bit opcode and a 32-bit immediate. The immediate is used only by the push-constant operation. The instruction set has eleven operations: push a constant, discard the top, three arithmetic operations, three signed comparisons, and three bitwise operations. There are no jumps or branches. Comparisons return an all-ones word for true and zero for false. This lets the bitwise operations combine those results as masks to build branch-free selects.

After every edge the core shows the current depth and the top-of-stack value. For every executed operation it raises a one-cycle trace strobe. The strobe carries the opcode, both operands consumed and the result produced, so a trace checker can compare it against a software model. Stack underflow, stack overflow and undefined opcodes are reported as one-cycle error pulses, and in all three cases the stack is left untouched.

Top module: `stk_core`

## Requirements
- R1: While reset is held, and until the internal reset release completes, `in_ready` is low. After release, depth and top-of-stack read 0 and no trace or error pulse is present.
- R2: Opcode encodings are: push 0, pop 1, add 2, sub 3, neg 4, eq 5, lt 6, gt 7, and 8, or 9, not 10. A push writes `in_imm` as the new top and raises depth by one. Its trace reports operand a = 0, operand b = 0 and result = `in_imm`.
- R3: A pop removes the top entry and lowers depth by one. Its trace reports b = the removed value, a = 0 and result = 0.
- R4: A binary operation removes two entries and pushes one, so depth drops by one. Operand a is the entry below the top and operand b is the top. sub computes a − b (17, 3 gives 14). add and sub wrap modulo 2^32.
- R5: neg and not replace the top entry and leave depth unchanged. neg is the two's-complement negation and wraps (neg 0x80000000 = 0x80000000). not is the full bitwise complement (not 0 = 0xFFFFFFFF). The trace reports b = old top and a = 0.
- R6: eq, lt and gt push 0xFFFFFFFF when a relates to b as named and 0 otherwise. lt and gt are signed (5 lt 3 = 0, 5 gt 3 = 0xFFFFFFFF, −1 lt 1 = 0xFFFFFFFF).
- R7: and and or act bitwise over the full 32-bit word (0xFF and 0x0F = 0x0F).
- R8: An operation that needs more entries than are present raises `err_underflow` for one cycle, does not change depth or contents, and produces no trace. pop, neg and not need one entry; binary operations need two.
- R9: A push while depth equals DEPTH raises `err_overflow` for one cycle, changes nothing and produces no trace.
- R10: Opcodes 11 to 15 raise `err_illegal` for one cycle, change nothing and produce no trace.
- R11: The trace strobe and the error pulses appear in the cycle after acceptance and last exactly one cycle. At most one of them is high in any cycle.
- R12: The mask-based select sequence push 7, push 3, gt, push 7, and, push 7, push 3, gt, not, push 3, and, or leaves the single entry 7, and so does the same sequence with 7 and 3 swapped. The range test push v, push 2, gt, push v, push 8, lt, and leaves 0xFFFFFFFF for v = 5 and 0 for v = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Core accepts an instruction this cycle |
| in_op | input | 4 | Opcode |
| in_imm | input | 32 | Immediate for push |
| depth | output | $clog2(DEPTH+1) | Current number of stack entries |
| tos | output | 32 | Top-of-stack value, 0 when empty |
| trc_valid | output | 1 | One-cycle strobe for an executed instruction |
| trc_op | output | 4 | Opcode of the traced instruction |
| trc_a | output | 32 | Left operand consumed (entry below top) |
| trc_b | output | 32 | Right operand consumed (top) |
| trc_res | output | 32 | Result pushed |
| err_underflow | output | 1 | Too few entries for the operation |
| err_overflow | output | 1 | Push onto a full stack |
| err_illegal | output | 1 | Undefined opcode |

## Verification
The bench builds the core with DEPTH = 4 instead of the default 16. With that depth, the overflow boundary is reached after four pushes, and the full-stack refusal can be checked against a known top value. The shallow stack still holds the three-deep intermediate state of the mask-select program, so both long sequences run unchanged. Underflow, illegal opcodes and signed comparison edges do not depend on depth and are exercised at the same setting.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_PUSH = 4'd0;
  localparam logic [OP_W-1:0] OP_POP  = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd3;
  localparam logic [OP_W-1:0] OP_NEG  = 4'd4;
  localparam logic [OP_W-1:0] OP_EQ   = 4'd5;
  localparam logic [OP_W-1:0] OP_LT   = 4'd6;
  localparam logic [OP_W-1:0] OP_GT   = 4'd7;
  localparam logic [OP_W-1:0] OP_AND  = 4'd8;
  localparam logic [OP_W-1:0] OP_OR   = 4'd9;
  localparam logic [OP_W-1:0] OP_NOT  = 4'd10;

  // shape of the stack effect of an opcode
  typedef enum logic [1:0] {
    SH_PUSH  = 2'd0,
    SH_POP   = 2'd1,
    SH_UNARY = 2'd2,
    SH_BIN   = 2'd3
  } shape_e;

  typedef struct packed {
    logic       legal;
    shape_e     shape;
    logic [1:0] need;   // entries required on the stack
  } dec_t;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec = '{legal: 1'b1, shape: SH_BIN, need: 2'd2};
    case (op)
      OP_PUSH: begin
        dec.shape = SH_PUSH;
        dec.need  = 2'd0;
      end
      OP_POP: begin
        dec.shape = SH_POP;
        dec.need  = 2'd1;
      end
      OP_NEG, OP_NOT: begin
        dec.shape = SH_UNARY;
        dec.need  = 2'd1;
      end
      OP_ADD, OP_SUB, OP_EQ, OP_LT, OP_GT, OP_AND, OP_OR: begin
        dec.shape = SH_BIN;
        dec.need  = 2'd2;
      end
      default: begin
        dec.legal = 1'b0;
        dec.shape = SH_PUSH;
        dec.need  = 2'd0;
      end
    endcase
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    res
);
  localparam logic [W-1:0] TRUE_W  = {W{1'b1}};
  localparam logic [W-1:0] FALSE_W = '0;

  logic eq_f, lt_f, gt_f;

  always_comb begin
    eq_f = (opa == opb);
    lt_f = ($signed(opa) < $signed(opb));
    gt_f = ($signed(opa) > $signed(opb));
  end

  always_comb begin
    case (op)
      OP_PUSH: res = imm;
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_NEG:  res = FALSE_W - opb;
      OP_EQ:   res = eq_f ? TRUE_W : FALSE_W;
      OP_LT:   res = lt_f ? TRUE_W : FALSE_W;
      OP_GT:   res = gt_f ? TRUE_W : FALSE_W;
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_NOT:  res = ~opb;
      default: res = FALSE_W;
    endcase
  end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     top,
  output logic [W-1:0]     below
);
  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en && (wr_idx == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wr_data;
      end
    end
    assign ent[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  // read ports: entry cnt-1 and entry cnt-2, zero when absent
  always_comb begin
    top   = '0;
    below = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) top   = ent[i];
      if (cnt == CNT_W'(i + 2)) below = ent[i];
    end
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [3:0]                   in_op,
  input  logic [31:0]                  in_imm,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic [31:0]                  tos,
  output logic                         trc_valid,
  output logic [3:0]                   trc_op,
  output logic [31:0]                  trc_a,
  output logic [31:0]                  trc_b,
  output logic [31:0]                  trc_res,
  output logic                         err_underflow,
  output logic                         err_overflow,
  output logic                         err_illegal
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i    = rst_q[1];
  assign in_ready = rst_i;

  // decode and operand fetch
  dec_t             dec;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      top_v, below_v, alu_res;
  logic             acc, short, full_push, exec;

  stk_decode u_dec (.op(in_op), .dec(dec));

  assign acc       = in_valid && in_ready;
  assign short     = dec.legal && (cnt < CNT_W'(dec.need));
  assign full_push = dec.legal && (dec.shape == SH_PUSH) && (cnt == FULL);
  assign exec      = acc && dec.legal && !short && !full_push;

  logic [31:0] opa, opb;
  always_comb begin
    opa = (dec.shape == SH_BIN) ? below_v : 32'd0;
    opb = (dec.legal && dec.shape != SH_PUSH) ? top_v : 32'd0;
  end

  stk_alu #(.W(WORD_W)) u_alu (
    .op(in_op), .opa(opa), .opb(opb), .imm(in_imm), .res(alu_res)
  );

  // next stack state
  logic [CNT_W-1:0] cnt_nxt, wr_idx;
  logic             wr_en;
  always_comb begin
    cnt_nxt = cnt;
    wr_idx  = cnt;
    wr_en   = 1'b0;
    case (dec.shape)
      SH_PUSH: begin
        cnt_nxt = cnt + CNT_W'(1);
        wr_idx  = cnt;
        wr_en   = exec;
      end
      SH_POP: begin
        cnt_nxt = cnt - CNT_W'(1);
      end
      SH_UNARY: begin
        wr_idx = cnt - CNT_W'(1);
        wr_en  = exec;
      end
      default: begin
        cnt_nxt = cnt - CNT_W'(1);
        wr_idx  = cnt - CNT_W'(2);
        wr_en   = exec;
      end
    endcase
  end

  stk_store #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_i), .cnt_en(exec), .cnt_nxt(cnt_nxt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(alu_res),
    .cnt(cnt), .top(top_v), .below(below_v)
  );

  assign depth = cnt;
  assign tos   = top_v;

  // trace and error reporting: next-state then register
  logic        trc_v_n, e_un_n, e_ov_n, e_il_n;
  logic [3:0]  trc_op_n;
  logic [31:0] trc_a_n, trc_b_n, trc_r_n;
  always_comb begin
    trc_v_n  = exec;
    trc_op_n = exec ? in_op   : trc_op;
    trc_a_n  = exec ? opa     : trc_a;
    trc_b_n  = exec ? opb     : trc_b;
    trc_r_n  = exec ? alu_res : trc_res;
    e_un_n   = acc && short;
    e_ov_n   = acc && full_push;
    e_il_n   = acc && !dec.legal;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      trc_valid     <= 1'b0;
      trc_op        <= '0;
      trc_a         <= '0;
      trc_b         <= '0;
      trc_res       <= '0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
      err_illegal   <= 1'b0;
    end else begin
      trc_valid     <= trc_v_n;
      trc_op        <= trc_op_n;
      trc_a         <= trc_a_n;
      trc_b         <= trc_b_n;
      trc_res       <= trc_r_n;
      err_underflow <= e_un_n;
      err_overflow  <= e_ov_n;
      err_illegal   <= e_il_n;
    end
  end
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [CNT_W-1:0] depth,
  input logic             trc_valid,
  input logic [3:0]       trc_op,
  input logic [31:0]      trc_res,
  input logic             err_underflow,
  input logic             err_overflow,
  input logic             err_illegal
);
  logic acc, is_bin, is_push, is_bad;
  assign acc     = in_valid && in_ready;
  assign is_push = (in_op == 4'd0);
  assign is_bin  = (in_op == 4'd2) || (in_op == 4'd3) || (in_op == 4'd5) ||
                   (in_op == 4'd6) || (in_op == 4'd7) || (in_op == 4'd8) ||
                   (in_op == 4'd9);
  assign is_bad  = (in_op > 4'd10);

  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  a_r4_binary_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_bin && depth >= CNT_W'(2) |=> depth == $past(depth) - CNT_W'(1));

  a_r6_cmp_mask: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid && (trc_op == 4'd5 || trc_op == 4'd6 || trc_op == 4'd7)
    |-> (trc_res == 32'd0 || trc_res == 32'hFFFF_FFFF));

  a_r8_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_bin && depth < CNT_W'(2) |=> err_underflow && !trc_valid && $stable(depth));

  a_r9_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_push && depth == CNT_W'(DEPTH) |=> err_overflow && !trc_valid && $stable(depth));

  a_r10_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_bad |=> err_illegal && !trc_valid && $stable(depth));

  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({trc_valid, err_underflow, err_overflow, err_illegal}) <= 1);

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !trc_valid && !err_underflow && !err_overflow && !err_illegal);
endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .depth(depth), .trc_valid(trc_valid), .trc_op(trc_op),
  .trc_res(trc_res), .err_underflow(err_underflow),
  .err_overflow(err_overflow), .err_illegal(err_illegal)
);

// File: tb/stk_core_test.sv
`timescale 1ns/1ps
module stk_core_test;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  localparam logic [3:0] PUSH = 4'd0, POP = 4'd1, ADD = 4'd2, SUB = 4'd3,
                         NEG = 4'd4, EQ = 4'd5, LT = 4'd6, GT = 4'd7,
                         AND_ = 4'd8, OR_ = 4'd9, NOT_ = 4'd10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_op = '0;
  logic [31:0]   in_imm = '0;
  logic [CW-1:0] depth;
  logic [31:0]   tos;
  logic          trc_valid;
  logic [3:0]    trc_op;
  logic [31:0]   trc_a, trc_b, trc_res;
  logic          err_underflow, err_overflow, err_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  stk_core #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm(in_imm), .depth(depth), .tos(tos),
    .trc_valid(trc_valid), .trc_op(trc_op), .trc_a(trc_a), .trc_b(trc_b),
    .trc_res(trc_res), .err_underflow(err_underflow),
    .err_overflow(err_overflow), .err_illegal(err_illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 ready low in reset", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // drive one instruction, sample one edge later
  task automatic issue(input logic [3:0] op, input logic [31:0] imm);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_imm   = imm;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic chk_state(input string req, input int d, input logic [31:0] t);
    chk({req, " depth"}, 32'(depth), 32'(d));
    chk({req, " top"}, tos, t);
  endtask

  task automatic chk_err(input string req, input logic u, input logic o, input logic i);
    chk({req, " flags"}, {28'd0, trc_valid, err_underflow, err_overflow, err_illegal},
        {28'd0, 1'b0, u, o, i});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ready", {31'd0, in_ready}, 32'd1);
    chk_state("R1", 0, 32'd0);
    chk("R1 quiet", {28'd0, trc_valid, err_underflow, err_overflow, err_illegal}, 32'd0);
  endtask

  task automatic t_push_pop();
    do_reset();
    issue(PUSH, 32'h11);
    issue(PUSH, 32'h22);
    chk_state("R2 push", 2, 32'h22);
    chk("R2 trace valid", {31'd0, trc_valid}, 32'd1);
    chk("R2 trace op", {28'd0, trc_op}, 32'd0);
    chk("R2 trace a", trc_a, 32'd0);
    chk("R2 trace b", trc_b, 32'd0);
    chk("R2 trace res", trc_res, 32'h22);
    issue(POP, 32'd0);
    chk_state("R3 pop", 1, 32'h11);
    chk("R3 trace b", trc_b, 32'h22);
    chk("R3 trace res", trc_res, 32'd0);
    @(posedge clk); #1;
    chk("R11 strobe one cycle", {31'd0, trc_valid}, 32'd0);
  endtask

  task automatic t_arith();
    do_reset();
    issue(PUSH, 32'd17);
    issue(PUSH, 32'd3);
    issue(SUB, 32'd0);
    chk_state("R4 sub", 1, 32'd14);
    chk("R4 trace a", trc_a, 32'd17);
    chk("R4 trace b", trc_b, 32'd3);
    chk("R4 trace op", {28'd0, trc_op}, 32'd3);
    issue(PUSH, 32'hFFFF_FFFF);
    issue(ADD, 32'd0);
    chk_state("R4 add wrap", 1, 32'd13);
  endtask

  task automatic t_unary();
    do_reset();
    issue(PUSH, 32'd5);
    issue(NEG, 32'd0);
    chk_state("R5 neg", 1, 32'hFFFF_FFFB);
    chk("R5 trace b", trc_b, 32'd5);
    chk("R5 trace a", trc_a, 32'd0);
    issue(PUSH, 32'd0);
    issue(NOT_, 32'd0);
    chk_state("R5 not", 2, 32'hFFFF_FFFF);
    issue(PUSH, 32'h8000_0000);
    issue(NEG, 32'd0);
    chk_state("R5 neg wrap", 3, 32'h8000_0000);
  endtask

  task automatic t_compare();
    do_reset();
    issue(PUSH, 32'd5); issue(PUSH, 32'd5); issue(EQ, 32'd0);
    chk_state("R6 eq", 1, 32'hFFFF_FFFF);
    issue(PUSH, 32'd5); issue(PUSH, 32'd3); issue(LT, 32'd0);
    chk_state("R6 lt false", 2, 32'd0);
    issue(PUSH, 32'd5); issue(PUSH, 32'd3); issue(GT, 32'd0);
    chk_state("R6 gt true", 3, 32'hFFFF_FFFF);
    do_reset();
    issue(PUSH, 32'hFFFF_FFFF); issue(PUSH, 32'd1); issue(LT, 32'd0);
    chk_state("R6 signed lt", 1, 32'hFFFF_FFFF);
    issue(PUSH, 32'd4); issue(EQ, 32'd0);
    chk_state("R6 eq false", 1, 32'd0);
  endtask

  task automatic t_bitwise();
    do_reset();
    issue(PUSH, 32'hFF); issue(PUSH, 32'h0F); issue(AND_, 32'd0);
    chk_state("R7 and", 1, 32'h0F);
    issue(PUSH, 32'hF0); issue(OR_, 32'd0);
    chk_state("R7 or", 1, 32'hFF);
  endtask

  task automatic t_underflow();
    do_reset();
    issue(ADD, 32'd0);
    chk_err("R8 add empty", 1'b1, 1'b0, 1'b0);
    chk_state("R8 add empty", 0, 32'd0);
    issue(POP, 32'd0);
    chk_err("R8 pop empty", 1'b1, 1'b0, 1'b0);
    issue(NOT_, 32'd0);
    chk_err("R8 not empty", 1'b1, 1'b0, 1'b0);
    issue(PUSH, 32'd9);
    issue(SUB, 32'd0);
    chk_err("R8 sub one", 1'b1, 1'b0, 1'b0);
    chk_state("R8 sub one", 1, 32'd9);
    @(posedge clk); #1;
    chk("R11 error one cycle", {31'd0, err_underflow}, 32'd0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= DEPTH; i++) issue(PUSH, 32'(i * 16));
    chk_state("R9 full", DEPTH, 32'(DEPTH * 16));
    issue(PUSH, 32'hDEAD);
    chk_err("R9 push full", 1'b0, 1'b1, 1'b0);
    chk_state("R9 push full", DEPTH, 32'(DEPTH * 16));
  endtask

  task automatic t_illegal();
    do_reset();
    issue(PUSH, 32'd3);
    issue(4'd11, 32'd7);
    chk_err("R10 op 11", 1'b0, 1'b0, 1'b1);
    chk_state("R10 op 11", 1, 32'd3);
    issue(4'd15, 32'd7);
    chk_err("R10 op 15", 1'b0, 1'b0, 1'b1);
    chk_state("R10 op 15", 1, 32'd3);
  endtask

  task automatic run_max(input logic [31:0] x, input logic [31:0] y);
    do_reset();
    issue(PUSH, x); issue(PUSH, y); issue(GT, 0); issue(PUSH, x); issue(AND_, 0);
    issue(PUSH, x); issue(PUSH, y); issue(GT, 0); issue(NOT_, 0);
    issue(PUSH, y); issue(AND_, 0); issue(OR_, 0);
  endtask

  task automatic t_max();
    run_max(32'd7, 32'd3);
    chk_state("R12 max 7,3", 1, 32'd7);
    run_max(32'd3, 32'd7);
    chk_state("R12 max 3,7", 1, 32'd7);
  endtask

  task automatic run_range(input logic [31:0] v);
    do_reset();
    issue(PUSH, v); issue(PUSH, 32'd2); issue(GT, 0);
    issue(PUSH, v); issue(PUSH, 32'd8); issue(LT, 0); issue(AND_, 0);
  endtask

  task automatic t_range();
    run_range(32'd5);
    chk_state("R12 range in", 1, 32'hFFFF_FFFF);
    run_range(32'd10);
    chk_state("R12 range out", 1, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_arith();
    t_unary();
    t_compare();
    t_bitwise();
    t_underflow();
    t_overflow();
    t_illegal();
    t_max();
    t_range();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule